// File: doc/BRIEF.md
# Time-Multiplexed Pseudo Dual-Port RAM

This block lets a single-port synchronous RAM serve a write-only port and a read-only port at the same time. Port A writes from its own clock, which has no fixed relation to the other two clocks. Port B reads from a read clock. The memory core runs from a third clock at an integer multiple (default three) of the read clock, and the rising edges of the two clocks line up.

Every write on port A is accepted at once and placed in a small dual-clock buffer. The memory domain drains the buffer into the array during the memory cycles that no read uses. In every read-clock period, exactly one memory cycle belongs to port B. Read latency is therefore fixed and never depends on write traffic.

A write can still be waiting in the buffer when a read asks for its address. For that case, the read address is compared with every pending entry, and the youngest matching entry overrides the array word.

Top module: `slot_pdp_ram`

## Requirements
- R1: `rdEn` and `rdAddr` are sampled on a rising `rdClk` edge. The addressed word appears on `rdData` at the next rising `rdClk` edge, and not before it.
- R2: When `rdEn` is low at a sampling edge, `rdData` keeps its previous value through the following edge.
- R3: A write is accepted on a rising `wrClk` edge at time T when `wrEn` is high and `wrFull` is low. Any read whose sampling edge comes at least one `rdClk` period after T returns that data, or the data of a younger write to the same address. This holds whether the word is still in the buffer or already in the array.
- R4: When several pending writes target one address, a read returns the data of the most recently accepted one.
- R5: Each `rdClk` period contains exactly one memory cycle reserved for the read, followed by `CLK_RATIO`-1 cycles. Each of those later cycles moves at most one buffered write into the array. The array is never written in the read cycle.
- R6: `wrFull` goes high once `WBUF_DEPTH` accepted writes are still waiting to be drained. If the write rate stays above the drain rate, `wrFull` is eventually raised.
- R7: A write presented while `wrFull` is high is discarded and changes no array word.
- R8: After reset, `rdData` is zero and `wrFull` is low, and every array word reads as zero until it is written.
- R9: Once the buffer has drained, each address holds the data of the last write accepted for it, in the order the writes were accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| rst_n | input | 1 | Asynchronous active-low reset for all three domains |
| wrClk | input | 1 | Write-port clock, asynchronous to the others |
| wrEn | input | 1 | Write request |
| wrAddr | input | ADDR_W | Write address |
| wrData | input | DATA_W | Write data |
| wrFull | output | 1 | Write buffer full; writes are discarded while high |
| rdClk | input | 1 | Read-port clock |
| rdEn | input | 1 | Read request |
| rdAddr | input | ADDR_W | Read address |
| rdData | output | DATA_W | Registered read data |
| memClk | input | 1 | Memory clock, CLK_RATIO times rdClk, edge-aligned |

## Verification
The assertions check the following on every cycle:
- the slot cadence (read cycles exactly `CLK_RATIO` memory cycles apart);
- that a drain happens only in a non-read cycle with a non-empty buffer;
- that every read-period request is served in its slot;
- that `rdData` holds when no read was issued;
- that the write pointer freezes while full;
- that buffer occupancy stays within depth.

Only the bench scenarios can show that the returned data is correct:
- freshness through forwarding while writes are backed up under a fast writer;
- youngest-wins among repeated writes to one address;
- that writes made while full leave no trace;
- zero contents after reset;
- the final array image after the buffer drains.

// File: rtl/slot_pdp_pkg.sv
package slot_pdp_pkg;

  // Strobes from the slot controller to the datapath, one set per memory cycle.
  typedef struct packed {
    logic rdSlot;  // this memory cycle belongs to port B
    logic wrSlot;  // this memory cycle may drain a posted write
    logic drain;   // a posted write is popped and committed now
  } slotStrb_t;

endpackage

// File: rtl/slot_pdp_wbuf.sv
module slot_pdp_wbuf #(
  parameter int AW    = 6,
  parameter int DW    = 16,
  parameter int DEPTH = 8
) (
  input  logic          wrClk,
  input  logic          memClk,
  input  logic          rst_n,
  input  logic          wrEn,
  input  logic [AW-1:0] wrAddr,
  input  logic [DW-1:0] wrData,
  output logic          wrFull,
  input  logic          pop,
  output logic          empty,
  output logic [AW-1:0] headAddr,
  output logic [DW-1:0] headData,
  input  logic [AW-1:0] lookupAddr,
  output logic          fwdHit,
  output logic [DW-1:0] fwdData
);
  // DEPTH must be a power of two, at least 4
  localparam int PW  = $clog2(DEPTH);
  localparam int PTR = PW + 1;
  typedef logic [PTR-1:0] ptr_t;

  function automatic ptr_t bin2gray(input ptr_t b);
    return b ^ (b >> 1);
  endfunction

  function automatic ptr_t gray2bin(input ptr_t g);
    ptr_t b;
    b[PTR-1] = g[PTR-1];
    for (int i = PTR - 2; i >= 0; i--) b[i] = b[i+1] ^ g[i];
    return b;
  endfunction

  logic [AW-1:0] entAddr [DEPTH];
  logic [DW-1:0] entData [DEPTH];

  ptr_t wrBin, wrGray, wrBinNxt, rdGrayS1, rdGrayS2;
  ptr_t rdBin, rdGray, rdBinNxt, wrGrayS1, wrGrayS2, wrSyncBin, occ;
  logic accept;
  logic [PW-1:0] scanIdx;

  // ---------------- write domain ----------------
  assign accept   = wrEn & ~wrFull;
  assign wrBinNxt = wrBin + PTR'(1);

  always_ff @(posedge wrClk or negedge rst_n) begin
    if (!rst_n) begin
      wrBin  <= '0;
      wrGray <= '0;
    end else if (accept) begin
      wrBin  <= wrBinNxt;
      wrGray <= bin2gray(wrBinNxt);
    end
  end

  always_ff @(posedge wrClk) begin
    if (accept) begin
      entAddr[wrBin[PW-1:0]] <= wrAddr;
      entData[wrBin[PW-1:0]] <= wrData;
    end
  end

  always_ff @(posedge wrClk or negedge rst_n) begin
    if (!rst_n) begin
      rdGrayS1 <= '0;
      rdGrayS2 <= '0;
    end else begin
      rdGrayS1 <= rdGray;
      rdGrayS2 <= rdGrayS1;
    end
  end

  assign wrFull = (wrGray == {~rdGrayS2[PTR-1:PTR-2], rdGrayS2[PTR-3:0]});

  // ---------------- memory domain ----------------
  assign rdBinNxt = rdBin + PTR'(1);

  always_ff @(posedge memClk or negedge rst_n) begin
    if (!rst_n) begin
      wrGrayS1 <= '0;
      wrGrayS2 <= '0;
    end else begin
      wrGrayS1 <= wrGray;
      wrGrayS2 <= wrGrayS1;
    end
  end

  always_ff @(posedge memClk or negedge rst_n) begin
    if (!rst_n) begin
      rdBin  <= '0;
      rdGray <= '0;
    end else if (pop) begin
      rdBin  <= rdBinNxt;
      rdGray <= bin2gray(rdBinNxt);
    end
  end

  assign wrSyncBin = gray2bin(wrGrayS2);
  assign empty     = (rdGray == wrGrayS2);
  assign occ       = wrSyncBin - rdBin;
  assign headAddr  = entAddr[rdBin[PW-1:0]];
  assign headData  = entData[rdBin[PW-1:0]];

  // Forwarding scan, oldest to youngest; a later match overrides.
  always_comb begin
    fwdHit  = 1'b0;
    fwdData = '0;
    scanIdx = '0;
    for (int k = 0; k < DEPTH; k++) begin
      scanIdx = rdBin[PW-1:0] + PW'(k);
      if ((PTR'(k) < occ) && (entAddr[scanIdx] == lookupAddr)) begin
        fwdHit  = 1'b1;
        fwdData = entData[scanIdx];
      end
    end
  end

  // R7
  full_drop_chk: assert property (@(posedge wrClk) disable iff (!rst_n)
    (wrEn && wrFull) |=> $stable(wrBin));

  // R6
  occupancy_chk: assert property (@(posedge memClk) disable iff (!rst_n)
    occ <= PTR'(DEPTH));

  // R5
  drain_guard_chk: assert property (@(posedge memClk) disable iff (!rst_n)
    pop |-> !empty);

endmodule

// File: rtl/slot_pdp_ctrl.sv
module slot_pdp_ctrl
  import slot_pdp_pkg::*;
#(
  parameter int RATIO = 3
) (
  input  logic      memClk,
  input  logic      rdClk,
  input  logic      rst_n,
  input  logic      fifoEmpty,
  output slotStrb_t strb
);
  localparam int GW = $clog2(RATIO + 1);

  logic rdTog, togSeen, readNow, locked;
  logic [GW-1:0] gapCnt;

  // Flips once per read period; the memory domain sees the flip on the
  // first memory edge after the read edge, which becomes the read slot.
  always_ff @(posedge rdClk or negedge rst_n) begin
    if (!rst_n) rdTog <= 1'b0;
    else        rdTog <= ~rdTog;
  end

  always_ff @(posedge memClk or negedge rst_n) begin
    if (!rst_n) togSeen <= 1'b0;
    else        togSeen <= rdTog;
  end

  assign readNow = rdTog ^ togSeen;

  always_comb begin
    strb.rdSlot = readNow;
    strb.wrSlot = ~readNow;
    strb.drain  = ~readNow & ~fifoEmpty;
  end

  // Memory cycles since the last read slot
  always_ff @(posedge memClk or negedge rst_n) begin
    if (!rst_n) begin
      gapCnt <= '0;
      locked <= 1'b0;
    end else if (readNow) begin
      gapCnt <= '0;
      locked <= 1'b1;
    end else if (gapCnt != GW'(RATIO)) begin
      gapCnt <= gapCnt + 1'b1;
    end
  end

  // R5
  slot_cadence_chk: assert property (@(posedge memClk) disable iff (!rst_n)
    (readNow && locked) |-> (gapCnt == GW'(RATIO - 1)));

endmodule

// File: rtl/slot_pdp_dpath.sv
module slot_pdp_dpath
  import slot_pdp_pkg::*;
#(
  parameter int AW = 6,
  parameter int DW = 16
) (
  input  logic          memClk,
  input  logic          rdClk,
  input  logic          rst_n,
  input  slotStrb_t     strb,
  input  logic          rdEn,
  input  logic [AW-1:0] rdAddr,
  input  logic [AW-1:0] drainAddr,
  input  logic [DW-1:0] drainData,
  input  logic          fwdHit,
  input  logic [DW-1:0] fwdData,
  output logic [AW-1:0] lookupAddr,
  output logic [DW-1:0] rdData
);
  localparam int WORDS = 1 << AW;

  logic [DW-1:0] memArr [WORDS] = '{default: '0};
  logic          reqEn;
  logic [AW-1:0] reqAddr;
  logic [DW-1:0] ramQ, fwdDataQ;
  logic          fwdHitQ, readDone;

  // Port B request capture (read clock)
  always_ff @(posedge rdClk or negedge rst_n) begin
    if (!rst_n) begin
      reqEn   <= 1'b0;
      reqAddr <= '0;
    end else begin
      reqEn   <= rdEn;
      reqAddr <= rdAddr;
    end
  end

  assign lookupAddr = reqAddr;

  // Single-port array: one write per drain slot
  always_ff @(posedge memClk) begin
    if (strb.drain) memArr[drainAddr] <= drainData;
  end

  // Read slot: array read plus forwarding snapshot
  always_ff @(posedge memClk or negedge rst_n) begin
    if (!rst_n) begin
      ramQ     <= '0;
      fwdDataQ <= '0;
      fwdHitQ  <= 1'b0;
      readDone <= 1'b0;
    end else if (strb.rdSlot) begin
      readDone <= reqEn;
      fwdHitQ  <= fwdHit & reqEn;
      fwdDataQ <= fwdData;
      if (reqEn) ramQ <= memArr[reqAddr];
    end
  end

  // Output register (read clock)
  always_ff @(posedge rdClk or negedge rst_n) begin
    if (!rst_n)        rdData <= '0;
    else if (readDone) rdData <= fwdHitQ ? fwdDataQ : ramQ;
  end

  // R5
  slot_excl_chk: assert property (@(posedge memClk) disable iff (!rst_n)
    strb.drain |-> (strb.wrSlot && !strb.rdSlot));

  // R1
  read_slot_chk: assert property (@(posedge rdClk) disable iff (!rst_n)
    readDone == reqEn);

  // R2
  rd_hold_chk: assert property (@(posedge rdClk) disable iff (!rst_n)
    !readDone |=> $stable(rdData));

endmodule

// File: rtl/slot_pdp_ram.sv
module slot_pdp_ram
  import slot_pdp_pkg::*;
#(
  parameter int ADDR_W     = 6,
  parameter int DATA_W     = 16,
  parameter int WBUF_DEPTH = 8,
  parameter int CLK_RATIO  = 3
) (
  input  logic              rst_n,
  input  logic              wrClk,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [DATA_W-1:0] wrData,
  output logic              wrFull,
  input  logic              rdClk,
  input  logic              rdEn,
  input  logic [ADDR_W-1:0] rdAddr,
  output logic [DATA_W-1:0] rdData,
  input  logic              memClk
);
  slotStrb_t           strb;
  logic                bufEmpty, fwdHit;
  logic [ADDR_W-1:0]   headAddr, lookupAddr;
  logic [DATA_W-1:0]   headData, fwdData;

  slot_pdp_wbuf #(.AW(ADDR_W), .DW(DATA_W), .DEPTH(WBUF_DEPTH)) wbuf_i (
    .wrClk(wrClk), .memClk(memClk), .rst_n(rst_n),
    .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData), .wrFull(wrFull),
    .pop(strb.drain), .empty(bufEmpty), .headAddr(headAddr), .headData(headData),
    .lookupAddr(lookupAddr), .fwdHit(fwdHit), .fwdData(fwdData)
  );

  slot_pdp_ctrl #(.RATIO(CLK_RATIO)) ctrl_i (
    .memClk(memClk), .rdClk(rdClk), .rst_n(rst_n),
    .fifoEmpty(bufEmpty), .strb(strb)
  );

  slot_pdp_dpath #(.AW(ADDR_W), .DW(DATA_W)) dpath_i (
    .memClk(memClk), .rdClk(rdClk), .rst_n(rst_n), .strb(strb),
    .rdEn(rdEn), .rdAddr(rdAddr), .drainAddr(headAddr), .drainData(headData),
    .fwdHit(fwdHit), .fwdData(fwdData), .lookupAddr(lookupAddr), .rdData(rdData)
  );

endmodule

// File: tb/slot_pdp_ram_tb_top.sv
module slot_pdp_ram_tb_top;
  localparam int MEM_PERIOD = 10;
  localparam int RD_PERIOD  = 3 * MEM_PERIOD;
  localparam int WR_PERIOD  = 12;   // faster than the drain rate, to back up the buffer
  localparam int AW = 6;
  localparam int DW = 16;
  localparam int RSV = 63;          // never legitimately written
  localparam int WD_CYCLES = 100000;

  logic rst_n, wrClk, rdClk, memClk;
  logic wrEn, rdEn, wrFull;
  logic [AW-1:0] wrAddr, rdAddr;
  logic [DW-1:0] wrData, rdData;

  logic [DW-1:0] shadow [64];
  time           lastWr [64];
  bit            wasWr  [64];
  int  nChk = 0, nFail = 0;
  bit  fullSeen = 0;

  slot_pdp_ram dut_i (
    .rst_n(rst_n), .wrClk(wrClk), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .wrFull(wrFull), .rdClk(rdClk), .rdEn(rdEn), .rdAddr(rdAddr), .rdData(rdData),
    .memClk(memClk)
  );

  initial memClk = 1'b0;
  always #(MEM_PERIOD / 2) memClk = ~memClk;
  initial rdClk = 1'b0;
  always #(RD_PERIOD / 2) rdClk = ~rdClk;
  initial begin
    wrClk = 1'b0;
    #1;
    forever #(WR_PERIOD / 2) wrClk = ~wrClk;
  end

  task automatic summary();
    $display("[TB] %0d tests run, %0d failed", nChk, nFail);
    $finish;
  endtask

  task automatic check(input string tag, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    nChk++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Expected read result: newest accepted write, zero if never written
  function automatic logic [DW-1:0] expWord(input int a);
    return wasWr[a] ? shadow[a] : '0;
  endfunction

  // A read is checkable once the newest write to its address is a read period old
  function automatic bit settled(input int a, input time tCap);
    return !wasWr[a] || ((tCap - lastWr[a]) >= RD_PERIOD);
  endfunction

  task automatic wrOne(input int a, input logic [DW-1:0] d);
    @(negedge wrClk);
    while (wrFull) @(negedge wrClk);
    wrEn = 1'b1; wrAddr = AW'(a); wrData = d;
    @(posedge wrClk);
    shadow[a] = d; lastWr[a] = $time; wasWr[a] = 1'b1;
  endtask

  task automatic wrIdle();
    @(negedge wrClk);
    wrEn = 1'b0;
  endtask

  task automatic rdOne(input int a, output logic [DW-1:0] early,
                       output logic [DW-1:0] act, output logic [DW-1:0] expV, output bit ok);
    @(negedge rdClk);
    rdEn = 1'b1; rdAddr = AW'(a);
    @(posedge rdClk);
    expV = expWord(a);
    ok   = settled(a, $time);
    @(negedge rdClk);
    rdEn = 1'b0; early = rdData;
    @(posedge rdClk);
    @(negedge rdClk);
    act = rdData;
  endtask

  task automatic wrBurst(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge wrClk);
      if (wrFull) begin
        fullSeen = 1'b1;
        if ($urandom % 2 == 0) begin
          wrEn = 1'b1; wrAddr = AW'(RSV); wrData = 16'hDEAD;  // must be dropped (R7)
        end else wrEn = 1'b0;
        @(posedge wrClk);
      end else if ($urandom % 10 == 0) begin
        wrEn = 1'b0;
        @(posedge wrClk);
      end else begin
        int a = int'($urandom % 8);
        logic [DW-1:0] d = DW'($urandom);
        wrEn = 1'b1; wrAddr = AW'(a); wrData = d;
        @(posedge wrClk);
        shadow[a] = d; lastWr[a] = $time; wasWr[a] = 1'b1;
      end
    end
    wrIdle();
  endtask

  task automatic rdBurst(input int n);
    for (int i = 0; i < n; i++) begin
      int r = int'($urandom % 9);
      int a = (r == 8) ? RSV : r;
      logic [DW-1:0] e, act, expV;
      bit ok;
      rdOne(a, e, act, expV, ok);
      if (ok) begin
        if (a == RSV) check("R7 write while full dropped", act, expV);
        else          check("R3/R4 fresh data under write backlog, fixed latency R5", act, expV);
      end
    end
  endtask

  initial begin
    #(WD_CYCLES * MEM_PERIOD);
    nFail++;
    $display("FAIL watchdog expired actual=running expected=done");
    summary();
  end

  initial begin
    logic [DW-1:0] e, act, expV;
    bit ok;
    void'($urandom(32'h1F2E3D4C));
    for (int i = 0; i < 64; i++) begin shadow[i] = '0; lastWr[i] = 0; wasWr[i] = 1'b0; end
    rst_n = 1'b0; wrEn = 1'b0; rdEn = 1'b0; wrAddr = '0; rdAddr = '0; wrData = '0;
    #52;
    check("R8 rdData after reset", rdData, '0);
    check("R8 wrFull after reset", {15'd0, wrFull}, '0);
    #50 rst_n = 1'b1;
    repeat (4) @(negedge rdClk);

    // R8: unwritten word reads zero
    rdOne(5, e, act, expV, ok);
    check("R8 unwritten word", act, 16'h0000);

    // R1: exact one-period latency
    wrOne(9, 16'h1234); wrIdle();
    #(2 * RD_PERIOD);
    rdOne(9, e, act, expV, ok);
    check("R1 no early update", e, 16'h0000);
    check("R1 data after one period", act, 16'h1234);

    // R2: output holds while no read is requested
    wrOne(9, 16'h5678); wrIdle();
    for (int i = 0; i < 3; i++) begin
      @(negedge rdClk);
      check("R2 hold without rdEn", rdData, 16'h1234);
    end
    rdOne(9, e, act, expV, ok);
    check("R3 newer write visible", act, 16'h5678);

    // R4: youngest of back-to-back writes to one address
    wrOne(2, 16'hA001); wrOne(2, 16'hA002); wrOne(2, 16'hA003); wrIdle();
    #(RD_PERIOD);
    rdOne(2, e, act, expV, ok);
    check("R4 youngest write wins", act, 16'hA003);

    // Concurrent random traffic, writer faster than drain
    fork
      wrBurst(400);
      rdBurst(120);
    join

    check("R6 full raised under sustained writes", {15'd0, fullSeen}, 16'h0001);

    // R9: final image after drain
    #(20 * RD_PERIOD);
    for (int a = 0; a < 8; a++) begin
      rdOne(a, e, act, expV, ok);
      check("R9 drained image", act, expWord(a));
    end
    rdOne(RSV, e, act, expV, ok);
    check("R7 reserved word untouched", act, 16'h0000);

    summary();
  end

endmodule